// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel buses, A and B, and can move data from either one to the other. Each direction has its own holding register. The A-to-B register takes its value from bus A, and the B-to-A register takes its value from bus B. Each register has its own load clock.

When a bus is driven, the value sent comes from one of two sources, chosen by a per-direction select line. It is either the live value on the opposite bus or the value held in that direction's register. An active-low drive enable and a direction input together decide which bus is driven: A, B or neither.

The buses are not modelled as inout nets. Each bus has a separate input vector, output vector and output-enable vector, and the enclosing design joins them to its pads or tri-state fabric.

The registers load on their clocks no matter what the drive controls are doing. A host can therefore park data from either bus while both buses are isolated, and replay it later.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `load_ab_clk` with `rst_n` high, the A-to-B register takes the value on `a_in`.
- R2: On each rising edge of `load_ba_clk` with `rst_n` high, the B-to-A register takes the value on `b_in`.
- R3: When `rst_n` is low at a rising edge of a register's own load clock, that register becomes all zeros. A low `rst_n` with no edge on a register's clock leaves that register unchanged.
- R4: While `drive_n` is 1 (isolation), `a_oe` and `b_oe` are both all zeros.
- R5: While `drive_n` is 0 and `toward_b` is 1, `b_oe` is all ones and `a_oe` is all zeros.
- R6: While `drive_n` is 0 and `toward_b` is 0, `a_oe` is all ones and `b_oe` is all zeros.
- R7: `b_out` equals `a_in` when `pick_store_ab` is 0 (live). It equals the A-to-B register when `pick_store_ab` is 1 (stored).
- R8: `a_out` equals `b_in` when `pick_store_ba` is 0 (live). It equals the B-to-A register when `pick_store_ba` is 1 (stored).
- R9: Both registers keep loading in isolation. They also keep loading whichever bus is the receiving side.
- R10: Each output-enable vector is either all ones or all zeros. `a_oe` and `b_oe` are never nonzero at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| load_ab_clk | input | 1 | Rising edge loads `a_in` into the A-to-B register |
| load_ba_clk | input | 1 | Rising edge loads `b_in` into the B-to-A register |
| rst_n | input | 1 | Synchronous active-low clear, sampled on each load clock |
| drive_n | input | 1 | Active-low drive enable; 1 isolates both buses |
| toward_b | input | 1 | 1 drives bus B from the A side, 0 drives bus A from the B side |
| pick_store_ab | input | 1 | 0 sends live `a_in` to B, 1 sends the A-to-B register |
| pick_store_ba | input | 1 | 0 sends live `b_in` to A, 1 sends the B-to-A register |
| a_in | input | W | Value seen on bus A |
| b_in | input | W | Value seen on bus B |
| a_out | output | W | Value offered to bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_out | output | W | Value offered to bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
The bench builds the block with the default width of 8. At this width, the alternating patterns 0xA5 and 0x5A, together with all-ones and all-zeros, expose any swapped, stuck or shared bit between the live path and the stored path. The two load clocks are pulsed one at a time. This brings within reach the cases where only one register should change, including a reset seen by one clock and not the other. Captures are also made under every drive setting, so a register gated by the enable or the direction would show a stale value once it is replayed.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = 8
) (
  input  logic         load_ab_clk,
  input  logic         load_ba_clk,
  input  logic         rst_n,
  input  logic         drive_n,
  input  logic         toward_b,
  input  logic         pick_store_ab,
  input  logic         pick_store_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  logic [W-1:0] held_ab;
  logic [W-1:0] held_ba;

  always_ff @(posedge load_ab_clk)
    if (!rst_n) held_ab <= '0;
    else        held_ab <= a_in;

  always_ff @(posedge load_ba_clk)
    if (!rst_n) held_ba <= '0;
    else        held_ba <= b_in;

  assign b_out = pick_store_ab ? held_ab : a_in;
  assign a_out = pick_store_ba ? held_ba : b_in;

  assign b_oe = {W{~drive_n &  toward_b}};
  assign a_oe = {W{~drive_n & ~toward_b}};

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W = 8
) (
  input logic         load_ab_clk,
  input logic         load_ba_clk,
  input logic         rst_n,
  input logic         drive_n,
  input logic         toward_b,
  input logic         pick_store_ab,
  input logic         pick_store_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe
);

  assert_ab_capture_R1: assert property (@(posedge load_ab_clk) disable iff (!rst_n)
    (pick_store_ab && $past(rst_n)) |-> b_out == $past(a_in));

  assert_ba_capture_R2: assert property (@(posedge load_ba_clk) disable iff (!rst_n)
    (pick_store_ba && $past(rst_n)) |-> a_out == $past(b_in));

  assert_ab_clear_R3: assert property (@(posedge load_ab_clk)
    (!rst_n && rst_n !== 1'bx) |=> (!pick_store_ab || b_out == '0));

  assert_isolate_R4: assert property (@(posedge load_ab_clk) disable iff (!rst_n)
    drive_n |-> (a_oe == '0 && b_oe == '0));

  assert_drive_b_R5: assert property (@(posedge load_ab_clk) disable iff (!rst_n)
    (!drive_n && toward_b) |-> (&b_oe && a_oe == '0));

  assert_drive_a_R6: assert property (@(posedge load_ba_clk) disable iff (!rst_n)
    (!drive_n && !toward_b) |-> (&a_oe && b_oe == '0));

  assert_live_ab_R7: assert property (@(posedge load_ab_clk) disable iff (!rst_n)
    !pick_store_ab |-> b_out == a_in);

  assert_live_ba_R8: assert property (@(posedge load_ba_clk) disable iff (!rst_n)
    !pick_store_ba |-> a_out == b_in);

  assert_one_bus_R10: assert property (@(posedge load_ab_clk) disable iff (!rst_n)
    !((|a_oe) && (|b_oe)) && (a_oe == '0 || &a_oe) && (b_oe == '0 || &b_oe));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (.*);

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic load_ab_clk = 1'b0, load_ba_clk = 1'b0, rst_n = 1'b0;
  logic drive_n = 1'b1, toward_b = 1'b0, pick_store_ab = 1'b0, pick_store_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bus_xcvr_reg #(.W(W)) u0 (.*);

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic pulse_ab();
    @(negedge clk) load_ab_clk = 1'b1;
    @(negedge clk) load_ab_clk = 1'b0;
    #1;
  endtask

  task automatic pulse_ba();
    @(negedge clk) load_ba_clk = 1'b1;
    @(negedge clk) load_ba_clk = 1'b0;
    #1;
  endtask

  task automatic read_stored(output logic [W-1:0] ab, output logic [W-1:0] ba);
    pick_store_ab = 1'b1; pick_store_ba = 1'b1; #1;
    ab = b_out; ba = a_out;
  endtask

  task automatic t_reset();
    logic [W-1:0] ab, ba;
    rst_n = 1'b0; a_in = 8'hFF; b_in = 8'hFF;
    pulse_ab(); pulse_ba();
    read_stored(ab, ba);
    check("R3 reset ab", ab, '0);
    check("R3 reset ba", ba, '0);
    check("R4 reset a_oe", a_oe, '0);
    check("R4 reset b_oe", b_oe, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_capture();
    logic [W-1:0] ab, ba;
    a_in = 8'hA5; b_in = 8'h5A;
    pulse_ab();
    read_stored(ab, ba);
    check("R1 ab load", ab, 8'hA5);
    check("R2 ba untouched", ba, 8'h00);
    pulse_ba();
    read_stored(ab, ba);
    check("R2 ba load", ba, 8'h5A);
    a_in = 8'h3C; b_in = 8'hC3; #1;
    read_stored(ab, ba);
    check("R1 no edge hold", ab, 8'hA5);
    check("R2 no edge hold", ba, 8'h5A);
  endtask

  task automatic t_select();
    pick_store_ab = 1'b0; pick_store_ba = 1'b0;
    a_in = 8'h0F; b_in = 8'hF0; #1;
    check("R7 live b_out", b_out, 8'h0F);
    check("R8 live a_out", a_out, 8'hF0);
    pick_store_ab = 1'b1; #1;
    check("R7 stored b_out", b_out, 8'hA5);
    pick_store_ba = 1'b1; #1;
    check("R8 stored a_out", a_out, 8'h5A);
    pick_store_ab = 1'b0; a_in = 8'hFF; #1;
    check("R7 live follow", b_out, 8'hFF);
  endtask

  task automatic t_drive();
    drive_n = 1'b1; toward_b = 1'b1; #1;
    check("R4 iso a_oe", a_oe, '0);
    check("R4 iso b_oe", b_oe, '0);
    drive_n = 1'b0; #1;
    check("R5 b_oe", b_oe, '1);
    check("R5 a_oe", a_oe, '0);
    toward_b = 1'b0; #1;
    check("R6 a_oe", a_oe, '1);
    check("R6 b_oe", b_oe, '0);
    check("R10 exclusive", a_oe & b_oe, '0);
  endtask

  task automatic t_capture_any_mode();
    logic [W-1:0] ab, ba;
    drive_n = 1'b1; a_in = 8'h11; b_in = 8'h22;
    pulse_ab(); pulse_ba();
    read_stored(ab, ba);
    check("R9 iso ab", ab, 8'h11);
    check("R9 iso ba", ba, 8'h22);
    drive_n = 1'b0; toward_b = 1'b1; a_in = 8'h33; b_in = 8'h44;
    pulse_ab(); pulse_ba();
    read_stored(ab, ba);
    check("R9 toward_b ab", ab, 8'h33);
    check("R9 toward_b ba", ba, 8'h44);
    toward_b = 1'b0; a_in = 8'h55; b_in = 8'h66;
    pulse_ab(); pulse_ba();
    read_stored(ab, ba);
    check("R9 toward_a ab", ab, 8'h55);
    check("R9 toward_a ba", ba, 8'h66);
  endtask

  task automatic t_split_reset();
    logic [W-1:0] ab, ba;
    rst_n = 1'b0;
    pulse_ab();
    read_stored(ab, ba);
    check("R3 ab cleared", ab, '0);
    check("R3 ba kept", ba, 8'h66);
    pulse_ba();
    read_stored(ab, ba);
    check("R3 ba cleared", ba, '0);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_capture();
    t_select();
    t_drive();
    t_capture_any_mode();
    t_split_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog got=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule